// File: doc/BRIEF.md
# Password-Gated Sector Memory Controller

This block is the byte-level protocol engine of a small secure memory. A two-wire bus front-end hands it decoded events: a start pulse, a stop pulse, a received byte, and a request for the next byte to transmit. The block returns an ACK/no-ACK decision for each received byte and supplies read data. Storage is a register array of `SECTORS` sectors of `BLK_BYTES` bytes each. Two `BLK_BYTES`-byte passwords, one guarding reads and one guarding writes, are kept in registers. Both passwords come out of reset as all zeros.

A transaction opens with a command byte, followed by the password bytes. Once the last password byte arrives, the block always starts a self-timed busy period of `NV_CYCLES` clocks, whatever the comparison result. This period stands in for the nonvolatile cycle and slows down password guessing. The host then issues a start and the poll code 55h. The block answers ACK only when the busy period is over and the password matched. After that ACK, the host streams data: sector data or a new password into the block, or bytes out of the array. A write or password change commits only at a stop that follows exactly `BLK_BYTES` data bytes, and that commit starts a new busy period.

The FSM states are `ST_IDLE` (standby, waiting for a start), `ST_CMD` (waiting for a command byte), `ST_PWD` (collecting password bytes), `ST_WDATA` (collecting write data) and `ST_RDATA` (serving read bytes). The transitions are as follows:
- A stop moves any state to `ST_IDLE`.
- A start moves any state to `ST_CMD`.
- In `ST_CMD`:
  - A legal command moves to `ST_PWD`.
  - A successful poll moves to `ST_RDATA` or `ST_WDATA`.
  - A byte received while busy moves to `ST_IDLE`.
  - An illegal command or a failed poll moves to `ST_IDLE`.
- The last password byte moves `ST_PWD` to `ST_IDLE`.

Top module: `secmem_ctrl`

## Requirements
- R1: Command bytes are encoded as follows, and each command byte receives its ACK decision one cycle after `rx_valid`:
  - Sector write is `{3'b100, s[3:0], 1'b0}` and sector read is `{3'b100, s[3:0], 1'b1}`, both with s < SECTORS.
  - Change write password is FCh and change read password is FEh.
  - These codes are ACKed. Every other byte, including sectors 14 and 15 and a 55h with no password outcome pending, gets no-ACK, and the block returns to standby.
- R2: Each of the `BLK_BYTES` password bytes is ACKed. The cycle after the last one, `busy` goes high and stays high for exactly `NV_CYCLES` clocks, whether or not the password matched.
- R3: Any command byte received while `busy` is high gets no-ACK. A pending password outcome survives this, so a later poll can still succeed.
- R4: A 55h poll after the busy period ACKs only if the latched password matched, and then opens the data phase. On a mismatch it gets no-ACK, the outcome is discarded and no read data is served.
- R5: A read is checked against the read password. A sector write and both password-change commands are checked against the write password.
- R6: A sector write stores its data only when the stop comes after exactly `BLK_BYTES` data bytes, and that stop starts the busy period. With fewer or more bytes, the sector and `busy` stay unchanged.
- R7: Read data starts at byte 0 of the addressed sector and continues through the following sectors for as long as `tx_req` pulses, with one byte one cycle after each request. After the last byte of the last sector it wraps to byte 0 of sector 0.
- R8: A start or stop during command, password or data input aborts the operation. Nothing is committed and no busy period begins.
- R9: A password change with exactly `BLK_BYTES` bytes replaces the selected password. The old value is rejected afterwards and the new one is accepted.
- R10: After reset, `ack_valid`, `tx_valid` and `busy` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ev_start | input | 1 | One-cycle pulse: start condition seen on the bus |
| ev_stop | input | 1 | One-cycle pulse: stop condition seen on the bus |
| rx_valid | input | 1 | One-cycle pulse: `rx_byte` holds a received byte |
| rx_byte | input | 8 | Received byte |
| tx_req | input | 1 | One-cycle pulse: front-end wants the next read byte |
| ack_valid | output | 1 | An ACK decision for the last received byte is present |
| ack_ok | output | 1 | 1 = ACK, 0 = no-ACK (valid with `ack_valid`) |
| tx_valid | output | 1 | `tx_byte` holds the requested read byte |
| tx_byte | output | 8 | Read data byte |
| busy | output | 1 | Self-timed busy period in progress |

## Verification
The command decoder is swept over all 256 byte values. This separates the 30 legal codes from the rest, including the out-of-range sector numbers and a stray poll code. Every sector is written with a distinct arithmetic pattern and read back in one long stream that runs past the end of the array. Reading this way tells correct sector addressing and wraparound apart from aliasing. Write bursts of seven, eight and nine bytes, and a burst cut off by a start, distinguish the single committing length from the aborting ones. A chain of password changes followed by attempts with each old and new value shows which stored password each command is checked against.

// File: rtl/secmem_pkg.sv
package secmem_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_CMD,
        ST_PWD,
        ST_WDATA,
        ST_RDATA
    } st_t;

    typedef enum logic [2:0] {
        OP_NONE,
        OP_READ,
        OP_WRITE,
        OP_SETW,
        OP_SETR
    } op_t;

    localparam logic [7:0] CODE_POLL = 8'h55;
    localparam logic [7:0] CODE_SETW = 8'hFC;
    localparam logic [7:0] CODE_SETR = 8'hFE;
    localparam int         SEC_FIELD_W = 4;

    // Map a command byte onto an operation; OP_NONE marks an illegal code.
    function automatic op_t decode_cmd(input logic [7:0] c, input int sectors);
        op_t r;
        r = OP_NONE;
        if (c == CODE_SETW) begin
            r = OP_SETW;
        end else if (c == CODE_SETR) begin
            r = OP_SETR;
        end else if (c[7:5] == 3'b100 && int'(c[4:1]) < sectors) begin
            r = c[0] ? OP_READ : OP_WRITE;
        end
        return r;
    endfunction

endpackage

// File: rtl/secmem_nvtimer.sv
module secmem_nvtimer #(
    parameter int NV_CYCLES = 5000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    output logic busy
);
    localparam int CW = $clog2(NV_CYCLES + 1);

    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (start) begin
            cnt_q <= CW'(NV_CYCLES);
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign busy = (cnt_q != '0);
endmodule

// File: rtl/secmem_pwd.sv
module secmem_pwd #(
    parameter int BLK_BYTES = 8,
    localparam int IDXW = $clog2(BLK_BYTES),
    localparam int BLKW = BLK_BYTES * 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            clr,
    input  logic            cmp_en,
    input  logic            cmp_sel_w,
    input  logic [IDXW-1:0] cmp_idx,
    input  logic [7:0]      cmp_byte,
    output logic            match_now,
    input  logic            upd_en,
    input  logic            upd_sel_w,
    input  logic [BLKW-1:0] upd_val
);
    logic [BLKW-1:0] pw_rd_q;
    logic [BLKW-1:0] pw_wr_q;
    logic            acc_q;
    logic [BLKW-1:0] sel_pw;
    logic            byte_eq;

    assign sel_pw    = cmp_sel_w ? pw_wr_q : pw_rd_q;
    assign byte_eq   = (sel_pw[cmp_idx*8 +: 8] == cmp_byte);
    assign match_now = acc_q & byte_eq;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pw_rd_q <= '0;
            pw_wr_q <= '0;
        end else if (upd_en) begin
            if (upd_sel_w) pw_wr_q <= upd_val;
            else           pw_rd_q <= upd_val;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            acc_q <= 1'b1;
        end else if (clr) begin
            acc_q <= 1'b1;
        end else if (cmp_en) begin
            acc_q <= match_now;
        end
    end
endmodule

// File: rtl/secmem_array.sv
module secmem_array
    import secmem_pkg::*;
#(
    parameter int SECTORS   = 14,
    parameter int BLK_BYTES = 8,
    localparam int TOTAL = SECTORS * BLK_BYTES,
    localparam int ADDRW = $clog2(TOTAL),
    localparam int BLKW  = BLK_BYTES * 8
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   we,
    input  logic [SEC_FIELD_W-1:0] wsec,
    input  logic [BLKW-1:0]        wdata,
    input  logic [ADDRW-1:0]       raddr,
    output logic [7:0]             rdata
);
    logic [7:0] mem [TOTAL];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < TOTAL; i++) mem[i] <= '0;
        end else if (we) begin
            for (int i = 0; i < TOTAL; i++) begin
                if (int'(wsec) == i / BLK_BYTES) mem[i] <= wdata[(i % BLK_BYTES)*8 +: 8];
            end
        end
    end

    assign rdata = (int'(raddr) < TOTAL) ? mem[raddr] : 8'h00;
endmodule

// File: rtl/secmem_ctrl.sv
module secmem_ctrl
    import secmem_pkg::*;
#(
    parameter int SECTORS   = 14,
    parameter int BLK_BYTES = 8,
    parameter int NV_CYCLES = 5000
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       ev_start,
    input  logic       ev_stop,
    input  logic       rx_valid,
    input  logic [7:0] rx_byte,
    input  logic       tx_req,
    output logic       ack_valid,
    output logic       ack_ok,
    output logic       tx_valid,
    output logic [7:0] tx_byte,
    output logic       busy
);
    localparam int TOTAL = SECTORS * BLK_BYTES;
    localparam int ADDRW = $clog2(TOTAL);
    localparam int CNTW  = $clog2(BLK_BYTES + 2);
    localparam int IDXW  = $clog2(BLK_BYTES);
    localparam int BLKW  = BLK_BYTES * 8;

    st_t                    state, state_nx;
    op_t                    op_q;
    op_t                    cmd_op;
    logic [SEC_FIELD_W-1:0] sec_q;
    logic [CNTW-1:0]        cnt_q;
    logic                   pend_q, pmatch_q;
    logic [BLKW-1:0]        wbuf_q;
    logic [ADDRW-1:0]       rptr_q;
    logic [7:0]             rdata;

    logic in_cmd, is_poll, poll_try, poll_hit, new_cmd;
    logic last_pwd, commit, arr_we, pw_we, nv_start;
    logic match_now, cmp_en, pwd_clr;

    assign cmd_op   = decode_cmd(rx_byte, SECTORS);
    assign in_cmd   = (state == ST_CMD) && rx_valid && !ev_start && !ev_stop;
    assign is_poll  = (rx_byte == CODE_POLL);
    assign poll_try = in_cmd && !busy && pend_q && is_poll;
    assign poll_hit = poll_try && pmatch_q;
    assign new_cmd  = in_cmd && !busy && !(pend_q && is_poll) && (cmd_op != OP_NONE);
    assign cmp_en   = (state == ST_PWD) && rx_valid && !ev_start && !ev_stop;
    assign last_pwd = cmp_en && (cnt_q == CNTW'(BLK_BYTES - 1));
    assign commit   = (state == ST_WDATA) && ev_stop && (cnt_q == CNTW'(BLK_BYTES));
    assign arr_we   = commit && (op_q == OP_WRITE);
    assign pw_we    = commit && (op_q == OP_SETW || op_q == OP_SETR);
    assign nv_start = last_pwd || commit;
    assign pwd_clr  = new_cmd;

    // Next-state logic
    always_comb begin
        state_nx = state;
        if (ev_stop) begin
            state_nx = ST_IDLE;
        end else if (ev_start) begin
            state_nx = ST_CMD;
        end else begin
            unique case (state)
                ST_IDLE: state_nx = ST_IDLE;
                ST_CMD: begin
                    if (rx_valid) begin
                        if (busy)          state_nx = ST_IDLE;
                        else if (poll_hit) state_nx = (op_q == OP_READ) ? ST_RDATA : ST_WDATA;
                        else if (new_cmd)  state_nx = ST_PWD;
                        else               state_nx = ST_IDLE;
                    end
                end
                ST_PWD:   if (last_pwd) state_nx = ST_IDLE;
                ST_WDATA: state_nx = ST_WDATA;
                ST_RDATA: state_nx = ST_RDATA;
                default:  state_nx = ST_IDLE;
            endcase
        end
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    // Output register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ack_valid <= 1'b0;
            ack_ok    <= 1'b0;
            tx_valid  <= 1'b0;
            tx_byte   <= '0;
        end else begin
            ack_valid <= 1'b0;
            ack_ok    <= 1'b0;
            tx_valid  <= 1'b0;
            if (rx_valid && !ev_start && !ev_stop) begin
                unique case (state)
                    ST_CMD: begin
                        ack_valid <= 1'b1;
                        ack_ok    <= poll_hit || new_cmd;
                    end
                    ST_PWD, ST_WDATA: begin
                        ack_valid <= 1'b1;
                        ack_ok    <= 1'b1;
                    end
                    default: ;
                endcase
            end
            if (tx_req && state == ST_RDATA && !ev_start && !ev_stop) begin
                tx_valid <= 1'b1;
                tx_byte  <= rdata;
            end
        end
    end

    // Transaction context
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            op_q     <= OP_NONE;
            sec_q    <= '0;
            cnt_q    <= '0;
            pend_q   <= 1'b0;
            pmatch_q <= 1'b0;
            wbuf_q   <= '0;
            rptr_q   <= '0;
        end else begin
            if (in_cmd && !busy) begin
                pend_q   <= 1'b0;
                pmatch_q <= 1'b0;
            end
            if (new_cmd) begin
                op_q  <= cmd_op;
                sec_q <= rx_byte[4:1];
                cnt_q <= '0;
            end
            if (poll_hit) begin
                cnt_q  <= '0;
                rptr_q <= ADDRW'(int'(sec_q) * BLK_BYTES);
            end
            if (cmp_en) begin
                cnt_q <= cnt_q + 1'b1;
                if (last_pwd) begin
                    pend_q   <= 1'b1;
                    pmatch_q <= match_now;
                end
            end
            if (state == ST_WDATA && rx_valid && !ev_start && !ev_stop) begin
                if (cnt_q < CNTW'(BLK_BYTES)) wbuf_q[int'(cnt_q)*8 +: 8] <= rx_byte;
                if (cnt_q <= CNTW'(BLK_BYTES)) cnt_q <= cnt_q + 1'b1;
            end
            if (state == ST_RDATA && tx_req && !ev_start && !ev_stop) begin
                rptr_q <= (int'(rptr_q) == TOTAL - 1) ? '0 : rptr_q + 1'b1;
            end
        end
    end

    secmem_nvtimer #(.NV_CYCLES(NV_CYCLES)) u_timer (
        .clk   (clk),
        .rst_n (rst_n),
        .start (nv_start),
        .busy  (busy)
    );

    secmem_pwd #(.BLK_BYTES(BLK_BYTES)) u_pwd (
        .clk       (clk),
        .rst_n     (rst_n),
        .clr       (pwd_clr),
        .cmp_en    (cmp_en),
        .cmp_sel_w (op_q != OP_READ),
        .cmp_idx   (cnt_q[IDXW-1:0]),
        .cmp_byte  (rx_byte),
        .match_now (match_now),
        .upd_en    (pw_we),
        .upd_sel_w (op_q == OP_SETW),
        .upd_val   (wbuf_q)
    );

    secmem_array #(.SECTORS(SECTORS), .BLK_BYTES(BLK_BYTES)) u_arr (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (arr_we),
        .wsec  (sec_q),
        .wdata (wbuf_q),
        .raddr (rptr_q),
        .rdata (rdata)
    );
endmodule

// File: rtl/secmem_ctrl_chk.sv
module secmem_ctrl_chk (
    input logic clk,
    input logic rst_n,
    input logic ev_stop,
    input logic rx_valid,
    input logic tx_req,
    input logic ack_valid,
    input logic ack_ok,
    input logic tx_valid,
    input logic busy,
    input logic arr_we,
    input logic pw_we
);
    // R1
    ack_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ack_valid |-> $past(rx_valid));

    // R3
    busy_nack_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(busy) && ack_valid) |-> !ack_ok);

    // R2
    busy_origin_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> ($past(rx_valid) || $past(ev_stop)));

    // R6
    array_commit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        arr_we |-> ev_stop);

    // R9
    pwd_commit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pw_we |-> (ev_stop && !arr_we));

    // R7
    tx_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tx_valid |-> $past(tx_req));
endmodule

bind secmem_ctrl secmem_ctrl_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .ev_stop   (ev_stop),
    .rx_valid  (rx_valid),
    .tx_req    (tx_req),
    .ack_valid (ack_valid),
    .ack_ok    (ack_ok),
    .tx_valid  (tx_valid),
    .busy      (busy),
    .arr_we    (arr_we),
    .pw_we     (pw_we)
);

// File: tb/sim_secmem_ctrl.sv
module sim_secmem_ctrl;
    localparam int CLK_PERIOD = 10;
    localparam int NSEC = 14;
    localparam int NBLK = 8;
    localparam int NV   = 40;
    localparam int TOT  = NSEC * NBLK;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic ev_start = 1'b0, ev_stop = 1'b0, rx_valid = 1'b0, tx_req = 1'b0;
    logic [7:0] rx_byte = '0;
    logic ack_valid, ack_ok, tx_valid, busy;
    logic [7:0] tx_byte;

    int n_chk = 0;
    int n_err = 0;
    logic [7:0] mdl [TOT];

    always #(CLK_PERIOD/2) clk = ~clk;

    secmem_ctrl #(.SECTORS(NSEC), .BLK_BYTES(NBLK), .NV_CYCLES(NV)) u0 (
        .clk(clk), .rst_n(rst_n), .ev_start(ev_start), .ev_stop(ev_stop),
        .rx_valid(rx_valid), .rx_byte(rx_byte), .tx_req(tx_req),
        .ack_valid(ack_valid), .ack_ok(ack_ok), .tx_valid(tx_valid),
        .tx_byte(tx_byte), .busy(busy)
    );

    task automatic check(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_err++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic pulse_start();
        @(negedge clk) ev_start = 1'b1;
        @(negedge clk) ev_start = 1'b0;
    endtask

    task automatic pulse_stop();
        @(negedge clk) ev_stop = 1'b1;
        @(negedge clk) ev_stop = 1'b0;
    endtask

    task automatic xfer(input logic [7:0] b, output logic av, output logic ok);
        @(negedge clk) begin rx_valid = 1'b1; rx_byte = b; end
        @(negedge clk) rx_valid = 1'b0;
        av = ack_valid;
        ok = ack_ok;
    endtask

    task automatic rd(output logic [7:0] d, output logic v);
        @(negedge clk) tx_req = 1'b1;
        @(negedge clk) tx_req = 1'b0;
        v = tx_valid;
        d = tx_byte;
    endtask

    task automatic wait_idle();
        int n = 0;
        while (busy && n < 1000) begin
            @(negedge clk);
            n++;
        end
    endtask

    function automatic logic [63:0] pattern(input int s);
        logic [63:0] r;
        for (int i = 0; i < NBLK; i++) r[i*8 +: 8] = 8'(s*29 + i*7 + 3);
        return r;
    endfunction

    task automatic auth(input logic [7:0] cmd, input logic [63:0] pw, output logic granted);
        logic av, ok;
        pulse_start();
        xfer(cmd, av, ok);
        check("R1 legal command acked", int'(av & ok), 1);
        for (int i = 0; i < NBLK; i++) begin
            xfer(pw[i*8 +: 8], av, ok);
            check("R2 password byte acked", int'(av & ok), 1);
        end
        check("R2 busy after password", int'(busy), 1);
        wait_idle();
        pulse_start();
        xfer(8'h55, av, ok);
        granted = av & ok;
    endtask

    task automatic write_burst(input logic [7:0] cmd, input logic [63:0] pw,
                               input logic [63:0] data, input int n, input bit by_stop);
        logic g, av, ok;
        auth(cmd, pw, g);
        check("R4 poll grants write", int'(g), 1);
        for (int i = 0; i < n; i++) begin
            xfer(data[(i % NBLK)*8 +: 8], av, ok);
            check("R6 data byte acked", int'(av & ok), 1);
        end
        if (by_stop) pulse_stop();
        else begin pulse_start(); pulse_stop(); end
        if (n == NBLK && by_stop) begin
            check("R6 busy starts at committing stop", int'(busy), 1);
            wait_idle();
        end else begin
            check("R8 no busy after aborted write", int'(busy), 0);
        end
    endtask

    task automatic read_cmp(input int sec, input logic [63:0] pw, input int n, input string tag);
        logic g, v;
        logic [7:0] d;
        auth(8'(8'h81 | (sec << 1)), pw, g);
        check("R4 poll grants read", int'(g), 1);
        for (int i = 0; i < n; i++) begin
            rd(d, v);
            check(tag, int'(v), 1);
            check(tag, int'(d), int'(mdl[(sec*NBLK + i) % TOT]));
        end
        pulse_stop();
    endtask

    task automatic deny(input logic [7:0] cmd, input logic [63:0] pw, input string tag);
        logic g;
        auth(cmd, pw, g);
        check(tag, int'(g), 0);
        pulse_stop();
    endtask

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        n_chk++;
        n_err++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin : main
        logic av, ok, g, v;
        logic [7:0] d;
        int cnt;
        logic [63:0] pw_w, pw_r;
        pw_w = 64'h0123456789ABCDEF;
        pw_r = 64'hFEDCBA9876543210;
        for (int i = 0; i < TOT; i++) mdl[i] = 8'h00;

        repeat (3) @(negedge clk);
        // R10 reset state
        check("R10 ack_valid in reset", int'(ack_valid), 0);
        check("R10 tx_valid in reset", int'(tx_valid), 0);
        check("R10 busy in reset", int'(busy), 0);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 sweep of every command byte
        for (int c = 0; c < 256; c++) begin
            bit legal;
            legal = ((c >> 5) == 4 && ((c >> 1) & 15) < NSEC) || c == 8'hFC || c == 8'hFE;
            pulse_start();
            xfer(8'(c), av, ok);
            check("R1 decision present", int'(av), 1);
            check("R1 command decode", int'(ok), int'(legal));
            pulse_stop();
            if (legal) check("R8 abort in password phase no busy", int'(busy), 0);
        end

        // R2 busy length, R4 grant, R7 first read from sector 0
        pulse_start();
        xfer(8'h81, av, ok);
        for (int i = 0; i < NBLK; i++) xfer(8'h00, av, ok);
        cnt = 0;
        while (busy && cnt < 1000) begin cnt++; @(negedge clk); end
        check("R2 busy length", cnt, NV);
        pulse_start();
        xfer(8'h55, av, ok);
        check("R4 poll after matching password", int'(av & ok), 1);
        rd(d, v);
        check("R7 first byte of erased sector", int'(d), 0);
        pulse_stop();

        // R3 poll while busy gets no-ACK, pending outcome kept
        pulse_start();
        xfer(8'h84, av, ok);
        for (int i = 0; i < NBLK; i++) xfer(8'h00, av, ok);
        pulse_start();
        xfer(8'h55, av, ok);
        check("R3 poll during busy is no-ACK", int'(av && !ok), 1);
        wait_idle();
        pulse_start();
        xfer(8'h55, av, ok);
        check("R3 pending outcome survives busy poll", int'(av & ok), 1);
        for (int i = 0; i < NBLK; i++) xfer(pattern(2)[i*8 +: 8], av, ok);
        pulse_stop();
        check("R6 busy starts at stop", int'(busy), 1);
        for (int i = 0; i < NBLK; i++) mdl[2*NBLK + i] = pattern(2)[i*8 +: 8];
        wait_idle();

        // R6 fill every sector, R7 stream through all and wrap
        for (int s = 0; s < NSEC; s++) begin
            write_burst(8'(8'h80 | (s << 1)), 64'h0, pattern(s), NBLK, 1'b1);
            for (int i = 0; i < NBLK; i++) mdl[s*NBLK + i] = pattern(s)[i*8 +: 8];
        end
        read_cmp(0, 64'h0, TOT + NBLK, "R7 stream and wrap from sector 0");
        read_cmp(12, 64'h0, 3*NBLK, "R7 wrap from sector 12");

        // R4 mismatch: no-ACK and no read data
        auth(8'h8B, 64'h1, g);
        check("R4 wrong password poll no-ACK", int'(g), 0);
        rd(d, v);
        check("R4 no data after refusal", int'(v), 0);
        pulse_stop();

        // R6 / R8 wrong lengths and abort by start leave sector 3 unchanged
        write_burst(8'h86, 64'h0, 64'hA5A5A5A5A5A5A5A5, NBLK - 1, 1'b1);
        write_burst(8'h86, 64'h0, 64'h5A5A5A5A5A5A5A5A, NBLK + 1, 1'b1);
        write_burst(8'h86, 64'h0, 64'h3C3C3C3C3C3C3C3C, NBLK, 1'b0);
        read_cmp(3, 64'h0, NBLK, "R6 sector unchanged after bad bursts");

        // R9 / R5 password changes
        write_burst(8'hFC, 64'h0, pw_w, NBLK, 1'b1);
        deny(8'h88, 64'h0, "R9 old write password rejected");
        write_burst(8'h88, pw_w, pattern(40), NBLK, 1'b1);
        for (int i = 0; i < NBLK; i++) mdl[4*NBLK + i] = pattern(40)[i*8 +: 8];
        deny(8'h89, pw_w, "R5 read not checked against write password");
        read_cmp(4, 64'h0, NBLK, "R9 write with new password stored");
        deny(8'hFE, 64'h0, "R5 read-password change needs write password");
        write_burst(8'hFE, pw_w, pw_r, NBLK, 1'b1);
        deny(8'h89, 64'h0, "R9 old read password rejected");
        read_cmp(4, pw_r, NBLK, "R9 new read password accepted");
        deny(8'h88, pw_r, "R5 write not checked against read password");

        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end
endmodule